// File: doc/BRIEF.md
# Atomic Wide Register Byte Window

This block places a register wider than one byte (two or three bytes, chosen by a parameter) behind a byte-wide I/O bus. An 8-bit processor can then read or write the whole value coherently, even though it does so one byte at a time. The bytes occupy consecutive addresses starting at a base address, with the least significant byte at the base.

A read of the lowest byte returns that byte's live value. On the same clock edge it freezes every higher byte into a read shadow. Later reads of the higher bytes return the frozen copy, so the software sees one consistent word even if the register behind the window keeps changing. Writes work the other way round. Lower-byte writes go only into a staging buffer. A write to the top byte commits the staged bytes and the new top byte to the underlying register as one full-width load.

The read shadow and the write staging buffer are separate storage, so reads and writes may be interleaved freely. The counter or peripheral behind the window is outside this block. It supplies the live value and accepts the load strobe and the load value.

Top module: `atomic_wide_reg`

## Requirements
- R1: Byte lane k (k = 0 for the least significant byte) answers at address BASE_ADDR + k, for k from 0 to NBYTES-1. A read or write at any other address returns 0 on io_rdata and changes neither the shadow nor the staging buffer. Such a write never raises reg_load.
- R2: A read of lane 0 returns bits [7:0] of the live input reg_cur in the same cycle, combinationally.
- R3: A read of lane 0 captures bits [W-1:8] of reg_cur into the read shadow at the clock edge that ends the read. A later read of lane k (k ≥ 1) returns shadow byte k-1, even if reg_cur has changed since the capture.
- R4: The shadow changes only on a lane-0 read. Reads of higher lanes leave it unchanged, and repeated higher-lane reads return the same byte.
- R5: A write to lane k with k < NBYTES-1 stores io_wdata into staging byte k and does not raise reg_load.
- R6: A write to the top lane raises reg_load for exactly one cycle, the cycle after the write's clock edge. reg_wval in that cycle holds io_wdata in the top byte and the staged bytes below it.
- R7: Writes never alter the read shadow, and reads never alter the staging buffer. A read between lower-byte writes and the top-byte write does not corrupt the committed value.
- R8: Reset clears the shadow and the staging buffer to zero and holds reg_load low. A higher-lane read before any lane-0 read returns 0.
- R9: Staged bytes survive a commit. A second top-lane write with no lower writes in between commits the previously staged lower bytes again.
- R10: io_rdata is 0 whenever io_rd is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W | I/O byte address |
| io_rd | input | 1 | Read strobe, one access per cycle |
| io_wr | input | 1 | Write strobe, one access per cycle |
| io_wdata | input | 8 | Write byte |
| io_rdata | output | 8 | Read byte, combinational, 0 when not reading a lane |
| reg_cur | input | NBYTES*8 | Live value of the underlying register |
| reg_load | output | 1 | One-cycle full-width load strobe |
| reg_wval | output | NBYTES*8 | Value to load when reg_load is high |

## Verification
A shadow captured at the wrong time or overwritten later shows up on the first higher-lane read after a lane-0 read. To expose this, the bench changes reg_cur between the two reads, so a stale or live byte returns a different value within that one access. A staging byte that is lost, or corrupted by an interleaved read or an out-of-range write, appears on reg_wval one cycle after the next top-lane write. A wrong strobe length appears as reg_load still high in the idle cycle that follows a commit. Decode faults show up either as non-zero io_rdata at a neighbouring address or as a load strobe raised by a write outside the window.

// File: rtl/awr_pkg.sv
package awr_pkg;

  typedef logic [7:0] byte_t;

  // True when addr selects byte lane idx of a window starting at base.
  function automatic logic lane_match(input int unsigned addr,
                                     input int unsigned base,
                                     input int unsigned idx);
    return addr == (base + idx);
  endfunction

  // Width in bits of the part of a word that lies above its lowest byte.
  function automatic int unsigned upper_bits(input int unsigned nbytes);
    return (nbytes - 1) * 8;
  endfunction

endpackage

// File: rtl/awr_lane_decode.sv
module awr_lane_decode #(
  parameter int unsigned NBYTES    = 3,
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned BASE_ADDR = 16
) (
  input  logic [ADDR_W-1:0] io_addr,
  output logic [NBYTES-1:0] lane_sel
);
  import awr_pkg::*;

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    assign lane_sel[g] = lane_match(32'(io_addr), BASE_ADDR, g);
  end

endmodule

// File: rtl/awr_read_shadow.sv
module awr_read_shadow #(
  parameter int unsigned NBYTES = 3,
  localparam int unsigned HI_W  = (NBYTES - 1) * 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            low_rd,
  input  logic [HI_W-1:0] live_hi,
  output logic [HI_W-1:0] shadow_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)      shadow_q <= '0;
    else if (low_rd) shadow_q <= live_hi;
  end

  // R3
  shadow_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_rd |=> shadow_q == $past(live_hi));

  // R4
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !low_rd |=> $stable(shadow_q));

endmodule

// File: rtl/awr_write_stage.sv
module awr_write_stage #(
  parameter int unsigned NBYTES = 3,
  localparam int unsigned W     = NBYTES * 8,
  localparam int unsigned LO_N  = NBYTES - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LO_N-1:0] lo_wr,
  input  logic            top_wr,
  input  logic [7:0]      wdata,
  output logic            reg_load,
  output logic [W-1:0]    reg_wval
);
  import awr_pkg::*;

  byte_t                stage_q [LO_N];
  logic [(LO_N*8)-1:0]  stage_flat;

  for (genvar g = 0; g < LO_N; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n)         stage_q[g] <= '0;
      else if (lo_wr[g])  stage_q[g] <= wdata;
    end
    assign stage_flat[g*8 +: 8] = stage_q[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_load <= 1'b0;
      reg_wval <= '0;
    end else begin
      reg_load <= top_wr;
      if (top_wr) reg_wval <= {wdata, stage_flat};
    end
  end

  // R6
  load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    top_wr |=> reg_load);

  // R5
  no_early_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !top_wr |=> !reg_load);

  // R7
  stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_wr == '0) |=> $stable(stage_flat));

endmodule

// File: rtl/atomic_wide_reg.sv
module atomic_wide_reg #(
  parameter int unsigned NBYTES    = 3,
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned BASE_ADDR = 16,
  localparam int unsigned W        = NBYTES * 8,
  localparam int unsigned HI_W     = (NBYTES - 1) * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic [W-1:0]      reg_cur,
  output logic              reg_load,
  output logic [W-1:0]      reg_wval
);
  import awr_pkg::*;

  logic [NBYTES-1:0] lane_sel;
  logic              low_rd_evt;
  logic              top_wr_evt;
  logic [NBYTES-2:0] lo_wr_evt;
  logic [HI_W-1:0]   shadow_q;
  byte_t             lane_byte [NBYTES];

  awr_lane_decode #(
    .NBYTES(NBYTES), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
  ) u_decode (
    .io_addr (io_addr),
    .lane_sel(lane_sel)
  );

  assign low_rd_evt = io_rd & lane_sel[0];
  assign top_wr_evt = io_wr & lane_sel[NBYTES-1];
  assign lo_wr_evt  = {(NBYTES-1){io_wr}} & lane_sel[NBYTES-2:0];

  awr_read_shadow #(.NBYTES(NBYTES)) u_shadow (
    .clk     (clk),
    .rst_n   (rst_n),
    .low_rd  (low_rd_evt),
    .live_hi (reg_cur[W-1:8]),
    .shadow_q(shadow_q)
  );

  awr_write_stage #(.NBYTES(NBYTES)) u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .lo_wr   (lo_wr_evt),
    .top_wr  (top_wr_evt),
    .wdata   (io_wdata),
    .reg_load(reg_load),
    .reg_wval(reg_wval)
  );

  // Lane 0 is live; every higher lane reads the frozen shadow.
  assign lane_byte[0] = reg_cur[7:0];
  for (genvar g = 1; g < NBYTES; g++) begin : g_rbyte
    assign lane_byte[g] = shadow_q[(g-1)*8 +: 8];
  end

  always_comb begin
    io_rdata = '0;
    for (int i = 0; i < NBYTES; i++) begin
      if (io_rd && lane_sel[i]) io_rdata |= lane_byte[i];
    end
  end

  // R1
  lane_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lane_sel));

  // R10
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |-> io_rdata == 8'h00);

  // R2
  live_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_rd_evt |-> io_rdata == reg_cur[7:0]);

endmodule

// File: tb/atomic_wide_reg_tb.sv
module atomic_wide_reg_tb;

  localparam int NB = 3;
  localparam int W  = NB * 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [5:0]    io_addr = '0;
  logic          io_rd = 1'b0;
  logic          io_wr = 1'b0;
  logic [7:0]    io_wdata = '0;
  logic [7:0]    io_rdata;
  logic [W-1:0]  reg_cur = '0;
  logic          reg_load;
  logic [W-1:0]  reg_wval;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  atomic_wide_reg #(.NBYTES(NB), .ADDR_W(6), .BASE_ADDR(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd),
    .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .reg_cur(reg_cur), .reg_load(reg_load), .reg_wval(reg_wval)
  );

  // op: 0 idle, 1 read, 2 write. Fields:
  // op[72:71] addr[70:65] wdata[64:57] cur[56:33] exp_rd[32:25] exp_load[24] exp_wval[23:0]
  localparam int NV = 19;
  localparam logic [72:0] VEC [NV] = '{
    {2'd1, 6'h10, 8'h00, 24'hA1B2C3, 8'hC3, 1'b0, 24'h0},      // R2 live low
    {2'd1, 6'h11, 8'h00, 24'h00FFEE, 8'hB2, 1'b0, 24'h0},      // R3 shadow not live
    {2'd1, 6'h12, 8'h00, 24'h00FFEE, 8'hA1, 1'b0, 24'h0},      // R3
    {2'd1, 6'h10, 8'h00, 24'h00FFEE, 8'hEE, 1'b0, 24'h0},      // R3 recapture
    {2'd1, 6'h12, 8'h00, 24'h00FFEE, 8'h00, 1'b0, 24'h0},      // R3
    {2'd1, 6'h11, 8'h00, 24'h00FFEE, 8'hFF, 1'b0, 24'h0},      // R4
    {2'd2, 6'h10, 8'h11, 24'h123456, 8'h00, 1'b0, 24'h0},      // R5
    {2'd1, 6'h11, 8'h00, 24'h123456, 8'hFF, 1'b0, 24'h0},      // R7 write left shadow
    {2'd2, 6'h11, 8'h22, 24'h123456, 8'h00, 1'b0, 24'h0},      // R5
    {2'd1, 6'h10, 8'h00, 24'h123456, 8'h56, 1'b0, 24'h0},      // R7 interleaved read
    {2'd2, 6'h12, 8'h33, 24'h123456, 8'h00, 1'b1, 24'h332211}, // R6 commit
    {2'd0, 6'h10, 8'h00, 24'h123456, 8'h00, 1'b0, 24'h0},      // R6 one cycle, R10
    {2'd2, 6'h12, 8'h44, 24'h123456, 8'h00, 1'b1, 24'h442211}, // R9 reuse stage
    {2'd1, 6'h13, 8'h00, 24'h123456, 8'h00, 1'b0, 24'h0},      // R1 out of range read
    {2'd2, 6'h0F, 8'h55, 24'h123456, 8'h00, 1'b0, 24'h0},      // R1 below base
    {2'd2, 6'h13, 8'h66, 24'h123456, 8'h00, 1'b0, 24'h0},      // R1 above top
    {2'd1, 6'h12, 8'h00, 24'h999999, 8'h12, 1'b0, 24'h0},      // R4 shadow kept
    {2'd1, 6'h11, 8'h00, 24'h999999, 8'h34, 1'b0, 24'h0},      // R4
    {2'd2, 6'h12, 8'h77, 24'h999999, 8'h00, 1'b1, 24'h772211}  // R1 stage untouched
  };

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic [1:0] op, input logic [5:0] a,
                        input logic [7:0] d, input logic [W-1:0] cur);
    io_addr  = a;
    io_rd    = (op == 2'd1);
    io_wr    = (op == 2'd2);
    io_wdata = d;
    reg_cur  = cur;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 load in reset", W'(reg_load), W'(0));
    rst_n = 1'b1;
    @(negedge clk);
    access(2'd1, 6'h11, 8'h00, 24'hFEDCBA);
    #1 check("R8 shadow reset", W'(io_rdata), W'(0));
    access(2'd2, 6'h12, 8'h9C, 24'hFEDCBA);
    @(posedge clk); #1;
    check("R8 stage reset", reg_wval, 24'h9C0000);
    check("R6 load after reset", W'(reg_load), W'(1));
    @(negedge clk);
    // R10 idle read data at base
    access(2'd0, 6'h10, 8'h00, 24'hFEDCBA);
    #1 check("R10 idle rdata", W'(io_rdata), W'(0));

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      access(VEC[i][72:71], VEC[i][70:65], VEC[i][64:57], VEC[i][56:33]);
      #1 check($sformatf("R1-R9 vec %0d rdata", i), W'(io_rdata), W'(VEC[i][32:25]));
      @(posedge clk); #1;
      check($sformatf("vec %0d load", i), W'(reg_load), W'(VEC[i][24]));
      if (VEC[i][24])
        check($sformatf("vec %0d wval", i), reg_wval, VEC[i][23:0]);
    end

    @(negedge clk);
    access(2'd0, 6'h00, 8'h00, 24'h0);
    @(posedge clk); #1;
    check("R6 strobe ends", W'(reg_load), W'(0));

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule